// File: doc/BRIEF.md
# Memory Access Watchpoint Unit

This block sits beside an arbitrated memory bus and watches every transaction that the arbiter grants. It holds four watchpoints. Each one has an inclusive address window, a mask of operation kinds and a mask of requesting clients. When a transaction falls in the window, uses an enabled operation and comes from at least one enabled client, the watchpoint fires. It then records that transaction for software to read and raises its interrupt.

Software sets up and services the unit through a word-addressed read/write register port. A fired watchpoint keeps its record until software acknowledges it. Clearing the interrupt takes two writes: an acknowledge in the watchpoint's own register block, and a write of that watchpoint's bit to the global interrupt acknowledge register. A per-watchpoint enable mask gates the global status. The interrupt output also names the lowest-numbered enabled watchpoint that is pending, so that software services that one first.

Top module: `mem_watch_unit`

## Requirements
- R1: After reset, every watchpoint is idle and holds a zero configuration, the enable mask and raw status are zero, and `irq` is low.
- R2: A watchpoint hits on a cycle with `txn_valid` high when `lo <= txn_addr <= hi` (both ends inclusive). The operation-mask bit indexed by `txn_op` must also be set (0 read, 1 write, 2 fetch, 3 atomic), and `txn_clients & client_mask` must be non-zero.
- R3: When an idle watchpoint hits, it records the following. The client field is `txn_clients & client_mask`. The address, operation and size fields take the transaction's values. The first-client field is the lowest set index of the client field.
- R4: A watchpoint that has fired ignores later hits, and its record stays unchanged, until it is acknowledged.
- R5: Any write to a watchpoint's acknowledge offset (9) returns it to idle, and the next hit records anew. Reading offset 9 returns 1 in bit 0 while the watchpoint is pending.
- R6: A fire sets that watchpoint's bit in the raw status. The bit is cleared only by writing 1 to it at global offset 2. Bits written 0 are left alone, and the per-watchpoint acknowledge does not clear it.
- R7: The masked status (global offset 1) equals raw status AND the enable mask (global offset 0). `irq` is high exactly when the masked status is non-zero.
- R8: While `irq` is high, `irq_wp` gives the lowest index set in the masked status.
- R9: Watchpoint `i` occupies register words `16*i + k`. Offsets k=0..3 hold low address, high address, operation mask and client mask. Offsets 4..8 hold the recorded clients, address, operation, first client and size. The global block starts at word 64.
- R10: Cycles with `txn_valid` low have no effect on any watchpoint, whatever the other transaction inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | A granted bus transaction is present this cycle |
| txn_addr | input | 32 | Transaction address |
| txn_op | input | 2 | Operation code: 0 read, 1 write, 2 fetch, 3 atomic |
| txn_clients | input | 14 | Set of clients taking part in the transaction |
| txn_size | input | 8 | Transfer size |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt: OR of the masked status |
| irq_wp | output | 2 | Lowest-numbered pending enabled watchpoint |

## Verification
The hardest states to reach from the ports are the ones between the two acknowledge levels. In one, a watchpoint has been acknowledged locally but its global bit is still set. In the other, the global bit has been cleared while the watchpoint is still frozen and a new hit arrives. Directed sequences drive each of these orderings and then read back the status and the record. A long random run then mixes overlapping windows, sparse client sets and random acknowledges at either level against a bench model, so that several watchpoints are pending at once under changing enable masks.

// File: rtl/mwu_pkg.sv
// Package: shared constants for the memory access watchpoint unit.
// Assumes word-addressed registers, 16 words per watchpoint block.
package mwu_pkg;
    localparam int OP_W     = 2;
    localparam int OPM_W    = 1 << OP_W;
    localparam int BLK_WORDS = 16;

    // Per-watchpoint register offsets
    localparam logic [3:0] OFS_LO     = 4'd0;
    localparam logic [3:0] OFS_HI     = 4'd1;
    localparam logic [3:0] OFS_OPM    = 4'd2;
    localparam logic [3:0] OFS_CLM    = 4'd3;
    localparam logic [3:0] OFS_CCL    = 4'd4;
    localparam logic [3:0] OFS_CADDR  = 4'd5;
    localparam logic [3:0] OFS_COP    = 4'd6;
    localparam logic [3:0] OFS_CFIRST = 4'd7;
    localparam logic [3:0] OFS_CSIZE  = 4'd8;
    localparam logic [3:0] OFS_ACK    = 4'd9;

    // Global block offsets
    localparam logic [3:0] GOFS_MASK  = 4'd0;
    localparam logic [3:0] GOFS_MSTAT = 4'd1;
    localparam logic [3:0] GOFS_RAW   = 4'd2;

    typedef enum logic [OP_W-1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_FETCH  = 2'd2,
        OP_ATOMIC = 2'd3
    } op_e;
endpackage

// File: rtl/mwu_matcher.sv
// Module: mwu_matcher
// Combinational hit test of one transaction against one watchpoint
// configuration. It also produces the selected client set and the
// lowest selected client. Assumes lo/hi are inclusive bounds.
module mwu_matcher #(
    parameter int ADDR_W      = 32,
    parameter int NUM_CLIENTS = 14,
    localparam int CL_IDW     = $clog2(NUM_CLIENTS)
) (
    input  logic                          valid,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [ADDR_W-1:0]             lo,
    input  logic [ADDR_W-1:0]             hi,
    input  logic [mwu_pkg::OP_W-1:0]      op,
    input  logic [mwu_pkg::OPM_W-1:0]     op_mask,
    input  logic [NUM_CLIENTS-1:0]        clients,
    input  logic [NUM_CLIENTS-1:0]        cl_mask,
    output logic                          hit,
    output logic [NUM_CLIENTS-1:0]        sel,
    output logic [CL_IDW-1:0]             first
);
    // Clients that are both present and watched
    always_comb sel = clients & cl_mask;

    // Lowest selected client index (scan from the top down)
    always_comb begin
        first = '0;
        for (int k = NUM_CLIENTS - 1; k >= 0; k--) begin
            if (sel[k]) first = CL_IDW'(k);
        end
    end

    // Full hit condition: window, operation and client all agree
    always_comb hit = valid && (addr >= lo) && (addr <= hi) && op_mask[op] && (|sel);
endmodule

// File: rtl/mwu_watchpoint.sv
// Module: mwu_watchpoint
// One watchpoint: configuration registers, a hit matcher, a pending
// flag and the record of the firing transaction. The record is frozen
// while pending. Assumes the parent decodes block select and ack.
module mwu_watchpoint #(
    parameter int ADDR_W      = 32,
    parameter int NUM_CLIENTS = 14,
    parameter int SIZE_W      = 8,
    parameter int DATA_W      = 32,
    localparam int CL_IDW     = $clog2(NUM_CLIENTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      ack_we,
    input  logic [3:0]                ofs,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      txn_valid,
    input  logic [ADDR_W-1:0]         txn_addr,
    input  logic [mwu_pkg::OP_W-1:0]  txn_op,
    input  logic [NUM_CLIENTS-1:0]    txn_clients,
    input  logic [SIZE_W-1:0]         txn_size,
    output logic                      fire,
    output logic                      pend,
    output logic [ADDR_W-1:0]         cap_addr,
    output logic [DATA_W-1:0]         rdata
);
    import mwu_pkg::*;

    logic [ADDR_W-1:0]      lo_q, hi_q;
    logic [OPM_W-1:0]       opm_q;
    logic [NUM_CLIENTS-1:0] clm_q;
    logic [NUM_CLIENTS-1:0] cap_cl_q;
    logic [OP_W-1:0]        cap_op_q;
    logic [CL_IDW-1:0]      cap_first_q;
    logic [SIZE_W-1:0]      cap_size_q;
    logic [ADDR_W-1:0]      cap_addr_q;

    logic                   hit;
    logic [NUM_CLIENTS-1:0] sel;
    logic [CL_IDW-1:0]      first;

    mwu_matcher #(.ADDR_W(ADDR_W), .NUM_CLIENTS(NUM_CLIENTS)) match_i (
        .valid   (txn_valid),
        .addr    (txn_addr),
        .lo      (lo_q),
        .hi      (hi_q),
        .op      (txn_op),
        .op_mask (opm_q),
        .clients (txn_clients),
        .cl_mask (clm_q),
        .hit     (hit),
        .sel     (sel),
        .first   (first)
    );

    // A hit only counts while idle
    always_comb fire = hit && !pend;

    // Configuration registers written through the register port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            opm_q <= '0;
            clm_q <= '0;
        end else if (cfg_we) begin
            case (ofs)
                OFS_LO:  lo_q  <= ADDR_W'(wdata);
                OFS_HI:  hi_q  <= ADDR_W'(wdata);
                OFS_OPM: opm_q <= OPM_W'(wdata);
                OFS_CLM: clm_q <= NUM_CLIENTS'(wdata);
                default: ;
            endcase
        end
    end

    // Pending flag: set by a fire, cleared by the local acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (fire)   pend <= 1'b1;
        else if (ack_we) pend <= 1'b0;
    end

    // Record of the firing transaction, loaded only on a fire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_cl_q    <= '0;
            cap_addr_q  <= '0;
            cap_op_q    <= '0;
            cap_first_q <= '0;
            cap_size_q  <= '0;
        end else if (fire) begin
            cap_cl_q    <= sel;
            cap_addr_q  <= txn_addr;
            cap_op_q    <= txn_op;
            cap_first_q <= first;
            cap_size_q  <= txn_size;
        end
    end

    always_comb cap_addr = cap_addr_q;

    // Read mux over this block's offsets
    always_comb begin
        case (ofs)
            OFS_LO:     rdata = DATA_W'(lo_q);
            OFS_HI:     rdata = DATA_W'(hi_q);
            OFS_OPM:    rdata = DATA_W'(opm_q);
            OFS_CLM:    rdata = DATA_W'(clm_q);
            OFS_CCL:    rdata = DATA_W'(cap_cl_q);
            OFS_CADDR:  rdata = DATA_W'(cap_addr_q);
            OFS_COP:    rdata = DATA_W'(cap_op_q);
            OFS_CFIRST: rdata = DATA_W'(cap_first_q);
            OFS_CSIZE:  rdata = DATA_W'(cap_size_q);
            OFS_ACK:    rdata = DATA_W'(pend);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/mwu_irq_ctrl.sv
// Module: mwu_irq_ctrl
// Global interrupt state: raw status bits set by fires and cleared by
// write-one acknowledges, an enable mask, masked status, the combined
// interrupt and the lowest pending index. Fires win over a same-cycle clear.
module mwu_irq_ctrl #(
    parameter int NUM_WP  = 4,
    localparam int WP_IDW = $clog2(NUM_WP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WP-1:0] fire,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_WP-1:0] wbits,
    output logic [NUM_WP-1:0] mask,
    output logic [NUM_WP-1:0] raw,
    output logic [NUM_WP-1:0] masked,
    output logic              irq,
    output logic [WP_IDW-1:0] irq_wp
);
    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wbits;
    end

    // Raw status: write-one-to-clear, new fires always land
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~(clr_we ? wbits : '0)) | fire;
    end

    // Gated status and combined interrupt
    always_comb masked = raw & mask;
    always_comb irq    = |masked;

    // Lowest-numbered pending enabled watchpoint
    always_comb begin
        irq_wp = '0;
        for (int k = NUM_WP - 1; k >= 0; k--) begin
            if (masked[k]) irq_wp = WP_IDW'(k);
        end
    end
endmodule

// File: rtl/mem_watch_unit.sv
// Module: mem_watch_unit (top)
// Bank of address/operation/client watchpoints on an arbitrated bus,
// with a word-addressed register port. Watchpoint i lives at words
// 16*i..16*i+15, the global block follows. Assumes one transaction
// per cycle at most and synchronous active-low reset.
module mem_watch_unit #(
    parameter int NUM_WP      = 4,
    parameter int ADDR_W      = 32,
    parameter int NUM_CLIENTS = 14,
    parameter int SIZE_W      = 8,
    parameter int DATA_W      = 32,
    localparam int REG_AW     = $clog2((NUM_WP + 1) * mwu_pkg::BLK_WORDS),
    localparam int WP_IDW     = $clog2(NUM_WP)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     txn_valid,
    input  logic [ADDR_W-1:0]        txn_addr,
    input  logic [1:0]               txn_op,
    input  logic [NUM_CLIENTS-1:0]   txn_clients,
    input  logic [SIZE_W-1:0]        txn_size,
    input  logic                     reg_we,
    input  logic [REG_AW-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     irq,
    output logic [WP_IDW-1:0]        irq_wp
);
    import mwu_pkg::*;

    localparam int BLK_W = REG_AW - 4;

    logic [BLK_W-1:0]  blk;
    logic [3:0]        ofs;
    logic [NUM_WP-1:0] wp_cfg_we, wp_ack_we, wp_fire, wp_pend;
    logic [NUM_WP-1:0] int_mask, int_raw, int_masked;
    logic [NUM_WP-1:0][ADDR_W-1:0] cap_addr_all;
    logic [DATA_W-1:0] wp_rdata [NUM_WP];
    logic              glob_sel, mask_we, clr_we;

    // Split the register address into block and offset
    always_comb begin
        blk = reg_addr[REG_AW-1:4];
        ofs = reg_addr[3:0];
    end

    // Global block decode
    always_comb begin
        glob_sel = (blk == BLK_W'(NUM_WP));
        mask_we  = reg_we && glob_sel && (ofs == GOFS_MASK);
        clr_we   = reg_we && glob_sel && (ofs == GOFS_RAW);
    end

    generate
        for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
            // Per-watchpoint write and acknowledge decode
            always_comb begin
                wp_cfg_we[i] = reg_we && (blk == BLK_W'(i));
                wp_ack_we[i] = wp_cfg_we[i] && (ofs == OFS_ACK);
            end

            mwu_watchpoint #(
                .ADDR_W(ADDR_W), .NUM_CLIENTS(NUM_CLIENTS),
                .SIZE_W(SIZE_W), .DATA_W(DATA_W)
            ) wp_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .cfg_we      (wp_cfg_we[i]),
                .ack_we      (wp_ack_we[i]),
                .ofs         (ofs),
                .wdata       (reg_wdata),
                .txn_valid   (txn_valid),
                .txn_addr    (txn_addr),
                .txn_op      (txn_op),
                .txn_clients (txn_clients),
                .txn_size    (txn_size),
                .fire        (wp_fire[i]),
                .pend        (wp_pend[i]),
                .cap_addr    (cap_addr_all[i]),
                .rdata       (wp_rdata[i])
            );
        end
    endgenerate

    mwu_irq_ctrl #(.NUM_WP(NUM_WP)) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (wp_fire),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wbits   (reg_wdata[NUM_WP-1:0]),
        .mask    (int_mask),
        .raw     (int_raw),
        .masked  (int_masked),
        .irq     (irq),
        .irq_wp  (irq_wp)
    );

    // Register read mux across watchpoint blocks and the global block
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WP; i++) begin
            if (blk == BLK_W'(i)) reg_rdata = wp_rdata[i];
        end
        if (glob_sel) begin
            case (ofs)
                GOFS_MASK:  reg_rdata = DATA_W'(int_mask);
                GOFS_MSTAT: reg_rdata = DATA_W'(int_masked);
                GOFS_RAW:   reg_rdata = DATA_W'(int_raw);
                default:    reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mwu_checker.sv
// Module: mwu_checker
// Temporal properties of the watchpoint unit, bound onto the top.
module mwu_checker #(
    parameter int NUM_WP  = 4,
    parameter int ADDR_W  = 32,
    localparam int WP_IDW = $clog2(NUM_WP)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          txn_valid,
    input logic [NUM_WP-1:0]             pend,
    input logic [NUM_WP-1:0]             fire,
    input logic [NUM_WP-1:0]             ack_we,
    input logic [NUM_WP-1:0]             mask,
    input logic [NUM_WP-1:0]             masked,
    input logic                          irq,
    input logic [WP_IDW-1:0]             irq_wp,
    input logic [NUM_WP-1:0][ADDR_W-1:0] cap_addr
);
    generate
        for (genvar i = 0; i < NUM_WP; i++) begin : g_chk
            // R4: record holds while the watchpoint stays pending
            p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[i] && $past(pend[i])) |-> $stable(cap_addr[i]));
            // R10: a watchpoint only becomes pending after a valid transaction
            p_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend[i]) |-> $past(txn_valid));
            // R5: a local acknowledge without a fire leaves it idle
            p_ack_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $past(ack_we[i] && !fire[i]) |-> !pend[i]);
            // R7: a disabled watchpoint never shows in masked status
            p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !mask[i] |-> !masked[i]);
        end
    endgenerate

    // R8: the reported index is pending and nothing lower is
    p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (masked[irq_wp] &&
                 ((masked & ~({NUM_WP{1'b1}} << irq_wp)) == '0)));
    // R7: no interrupt without masked status
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (masked == '0) |-> !irq);
endmodule

bind mem_watch_unit mwu_checker #(.NUM_WP(NUM_WP), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_valid (txn_valid),
    .pend      (wp_pend),
    .fire      (wp_fire),
    .ack_we    (wp_ack_we),
    .mask      (int_mask),
    .masked    (int_masked),
    .irq       (irq),
    .irq_wp    (irq_wp),
    .cap_addr  (cap_addr_all)
);

// File: tb/mem_watch_unit_tb_top.sv
`timescale 1ns/1ps
module mem_watch_unit_tb_top;
    localparam int NWP = 4;
    localparam int GB  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_valid = 1'b0;
    logic [31:0] txn_addr = '0;
    logic [1:0]  txn_op = '0;
    logic [13:0] txn_clients = '0;
    logic [7:0]  txn_size = '0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [1:0]  irq_wp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_lo [NWP], m_hi [NWP], m_ca [NWP];
    logic [3:0]  m_opm [NWP];
    logic [13:0] m_clm [NWP], m_cc [NWP];
    logic [1:0]  m_cop [NWP];
    logic [3:0]  m_cf [NWP];
    logic [7:0]  m_cs [NWP];
    logic [NWP-1:0] m_pend, m_raw, m_mask;

    mem_watch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_op(txn_op), .txn_clients(txn_clients), .txn_size(txn_size),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .irq_wp(irq_wp)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] low_idx(input logic [13:0] s);
        for (int k = 0; k < 14; k++) if (s[k]) return 4'(k);
        return 4'd0;
    endfunction

    function automatic logic [1:0] low_wp(input logic [NWP-1:0] s);
        for (int k = 0; k < NWP; k++) if (s[k]) return 2'(k);
        return 2'd0;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        // model update
        if (a >= GB) begin
            if (a == GB) m_mask = d[NWP-1:0];
            if (a == GB + 2) m_raw = m_raw & ~d[NWP-1:0];
        end else begin
            case (a % 16)
                0: m_lo[a/16]  = d;
                1: m_hi[a/16]  = d;
                2: m_opm[a/16] = d[3:0];
                3: m_clm[a/16] = d[13:0];
                9: m_pend[a/16] = 1'b0;
                default: ;
            endcase
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 7'(a);
        #1 d = reg_rdata;
    endtask

    task automatic txn(input logic v, input logic [31:0] a, input logic [1:0] op,
                       input logic [13:0] cl, input logic [7:0] sz);
        @(negedge clk);
        txn_valid = v; txn_addr = a; txn_op = op; txn_clients = cl; txn_size = sz;
        @(negedge clk);
        txn_valid = 1'b0;
        for (int i = 0; i < NWP; i++) begin
            if (v && a >= m_lo[i] && a <= m_hi[i] && m_opm[i][op] &&
                (cl & m_clm[i]) != 0 && !m_pend[i]) begin
                m_pend[i] = 1'b1; m_raw[i] = 1'b1;
                m_cc[i] = cl & m_clm[i]; m_ca[i] = a; m_cop[i] = op;
                m_cf[i] = low_idx(cl & m_clm[i]); m_cs[i] = sz;
            end
        end
    endtask

    task automatic chk_irq(input string req);
        logic [NWP-1:0] ms;
        ms = m_raw & m_mask;
        chk({req, " irq"}, 32'(irq), 32'(|ms));
        if (|ms) chk("R8", 32'(irq_wp), 32'(low_wp(ms)));
    endtask

    task automatic chk_record(input int i, input string req);
        logic [31:0] d;
        rd(i*16 + 9, d); chk({req, " pend"}, d, 32'(m_pend[i]));
        rd(i*16 + 4, d); chk({req, " clients"}, d, 32'(m_cc[i]));
        rd(i*16 + 5, d); chk({req, " addr"}, d, m_ca[i]);
        rd(i*16 + 6, d); chk({req, " op"}, d, 32'(m_cop[i]));
        rd(i*16 + 7, d); chk({req, " first"}, d, 32'(m_cf[i]));
        rd(i*16 + 8, d); chk({req, " size"}, d, 32'(m_cs[i]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0001));
        for (int i = 0; i < NWP; i++) begin
            m_lo[i] = 0; m_hi[i] = 0; m_opm[i] = 0; m_clm[i] = 0;
            m_cc[i] = 0; m_ca[i] = 0; m_cop[i] = 0; m_cf[i] = 0; m_cs[i] = 0;
        end
        m_pend = '0; m_raw = '0; m_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", 32'(irq), 0);
        rd(GB, d);     chk("R1 mask", d, 0);
        rd(GB + 2, d); chk("R1 raw", d, 0);
        rd(16 + 1, d); chk("R1 hi", d, 0);
        chk_record(3, "R1");

        // R9: configuration readback at the mapped words
        wr(2*16 + 0, 32'h0000_1234); wr(2*16 + 1, 32'h0000_5678);
        wr(2*16 + 2, 32'h5);         wr(2*16 + 3, 32'h2A5A);
        rd(2*16 + 0, d); chk("R9 lo", d, 32'h1234);
        rd(2*16 + 1, d); chk("R9 hi", d, 32'h5678);
        rd(2*16 + 2, d); chk("R9 opm", d, 32'h5);
        rd(2*16 + 3, d); chk("R9 clm", d, 32'h2A5A);
        wr(2*16 + 2, 0);

        // R2 boundaries: window 100..200, writes only, client 3
        wr(0, 100); wr(1, 200); wr(2, 32'b0010); wr(3, 32'h8); wr(GB, 32'hF);
        txn(1, 99,  1, 14'h8, 8'd4);  rd(9, d); chk("R2 below lo", d, 0);
        txn(1, 201, 1, 14'h8, 8'd4);  rd(9, d); chk("R2 above hi", d, 0);
        txn(1, 150, 0, 14'h8, 8'd4);  rd(9, d); chk("R2 op masked", d, 0);
        txn(1, 150, 1, 14'h30, 8'd4); rd(9, d); chk("R2 client masked", d, 0);
        // R10: matching fields but not valid
        txn(0, 150, 1, 14'h8, 8'd4);  rd(9, d); chk("R10 invalid", d, 0);
        chk_irq("R10");
        // R2/R3: hit at inclusive top bound, clients 3 and 5 present
        txn(1, 200, 1, 14'h28, 8'd16);
        chk_irq("R7");
        chk_record(0, "R3");
        // R4: a second hit is ignored
        txn(1, 100, 1, 14'h8, 8'd2);
        chk_record(0, "R4");
        // R6: local ack keeps the global bit
        wr(9, 0);
        rd(GB + 2, d); chk("R6 raw after local ack", d, 1);
        chk_irq("R6");
        wr(GB + 2, 32'hE);
        rd(GB + 2, d); chk("R6 zero bit kept", d, 1);
        wr(GB + 2, 32'h1);
        rd(GB + 2, d); chk("R6 cleared", d, 0);
        chk("R6 irq low", 32'(irq), 0);
        // R5: after ack a new hit records anew
        txn(1, 100, 1, 14'h8, 8'd2);
        chk_record(0, "R5");
        // Global cleared while still frozen: new hit must not re-raise
        wr(GB + 2, 32'h1);
        txn(1, 120, 1, 14'h8, 8'd9);
        rd(GB + 2, d); chk("R4 no refire", d, 0);
        chk_record(0, "R4");
        wr(9, 0);

        // R8: overlapping watchpoints 1 and 3
        wr(16 + 0, 500); wr(16 + 1, 600); wr(16 + 2, 32'hF); wr(16 + 3, 32'h3FFF);
        wr(48 + 0, 550); wr(48 + 1, 560); wr(48 + 2, 32'hF); wr(48 + 3, 32'h3FFF);
        txn(1, 555, 3, 14'h2000, 8'd1);
        chk_irq("R8");
        wr(GB, 32'hD);
        chk_irq("R8 masked");
        rd(GB + 1, d); chk("R7 masked status", d, 32'h8);
        wr(GB, 32'hF);
        for (int i = 0; i < NWP; i++) wr(i*16 + 9, 0);
        wr(GB + 2, 32'hF);

        // Random phase
        for (int i = 0; i < NWP; i++) begin
            logic [31:0] lo;
            lo = $urandom_range(0, 255);
            wr(i*16 + 0, lo);
            wr(i*16 + 1, lo + $urandom_range(0, 127));
            wr(i*16 + 2, 32'($urandom_range(1, 15)));
            wr(i*16 + 3, 32'($urandom & 14'h3FFF));
        end
        wr(GB, 32'($urandom_range(0, 15)));
        for (int it = 0; it < 400; it++) begin
            txn(($urandom_range(0, 9) != 0), $urandom_range(0, 400),
                2'($urandom), 14'($urandom & $urandom), 8'($urandom));
            chk_irq("R7");
            case ($urandom_range(0, 11))
                0: wr($urandom_range(0, NWP-1)*16 + 9, 0);
                1: wr(GB + 2, 32'($urandom_range(0, 15)));
                2: wr(GB, 32'($urandom_range(0, 15)));
                default: ;
            endcase
            if (it % 16 == 15) begin
                rd(GB + 1, d); chk("R7 masked status", d, 32'(m_raw & m_mask));
                chk_record($urandom_range(0, NWP-1), "R3");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule